// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block makes the timing skeleton of a raster display. Each line has five phases, always in the same order: a reference lead-in, the sync pulse, the back porch, the visible span and the front porch. Frames are built from lines in the same five-phase order. The block advances one pixel step on each clock where the pixel-clock enable is high. From that position it drives active-high horizontal and vertical sync, a data-enable flag and the pixel coordinates inside the visible area.

Software programs five 32-bit words. Four of them give one phase length each, with the horizontal count in the low half and the vertical count, in lines, in the high half. The fifth word gives the visible width and height in the same layout. The reference lead-in is normally set to 1 on both axes, and one is taken off the panel's front margin to pay for it, so the line and frame totals stay the same. The block only produces timing: it accepts nothing and has no valid/ready flow and no back-pressure. The enable input is a plain strobe and cannot be stalled by the block.

The block copies the configuration words into internal shadow copies on the first clock after reset and again at the end of each frame. Writes made in the middle of a frame therefore never bend that frame.

Top module: `disp_sync_gen`

## Requirements
- R1: A line consists of the reference, sync, back porch, active and front porch phases in that order. Their lengths in pixel steps come from bits 15:0 of `tm_ref`, `tm_sync`, `tm_back`, `tm_active` and `tm_front`. After the front porch the next line starts again at the reference phase.
- R2: A frame takes lines through the same five phases in the same order, using bits 31:16 of the same words as line counts. The vertical phase advances only on the step that ends a line, so `vsync` changes only at a line start.
- R3: `hsync` is high exactly during the horizontal sync phase, and `vsync` is high exactly during the vertical sync lines. Both are active high.
- R4: `de` is high only when the horizontal and the vertical position are both in their active phase.
- R5: `pos_x` is 0 on the first active pixel of a line and rises by one per step through the active span. Outside the active span it holds its last value. `pos_y` behaves the same way per line within the active lines. Both are 0 from reset until their first active region.
- R6: The active word carries the width in bits 15:0 and the height in bits 31:16. A width above MAX_W (default 1366) is treated as MAX_W, and a height above MAX_H (default 768) is treated as MAX_H.
- R7: Any phase length programmed as 0, on either axis, is treated as 1.
- R8: Configuration words are sampled only on the first clock after reset and on the step that ends a frame. A change at any other time first shows in the next frame.
- R9: On a clock with `pix_ce` low, no output changes. `pix_ce` is ignored on the first clock after reset, because the configuration is loaded on that clock.
- R10: During and right after reset, `hsync`, `vsync` and `de` are low and `pos_x` and `pos_y` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel step enable |
| tm_ref | input | 32 | Reference phase lengths {vertical, horizontal} |
| tm_sync | input | 32 | Sync phase lengths {vertical, horizontal} |
| tm_back | input | 32 | Back porch lengths {vertical, horizontal} |
| tm_front | input | 32 | Front porch lengths {vertical, horizontal} |
| tm_active | input | 32 | Visible size {height, width} |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pos_x | output | 16 | Pixel column inside the active area |
| pos_y | output | 16 | Line index inside the active area |

## Verification
The properties assume three things:
- Reset is held for at least one clock.
- `pix_ce` is low while reset is asserted.
- Configuration words change only between clock edges.

They make no assumption about when the configuration changes relative to the frame. The stimulus drives every input on the falling edge and keeps `pix_ce` low during reset. It rewrites the configuration words in the middle of a frame on purpose, so that the frame-boundary sampling of R8 is exercised rather than assumed.

// File: rtl/disp_sync_pkg.sv
package disp_sync_pkg;

  localparam int unsigned NPH = 5;

  typedef enum logic [2:0] {
    PH_REF   = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_t;

  function automatic phase_t next_phase(input phase_t p);
    phase_t n;
    case (p)
      PH_REF:   n = PH_SYNC;
      PH_SYNC:  n = PH_BACK;
      PH_BACK:  n = PH_ACT;
      PH_ACT:   n = PH_FRONT;
      default:  n = PH_REF;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/disp_sync_cfg.sv
module disp_sync_cfg
  import disp_sync_pkg::*;
#(
  parameter int FW    = 16,
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NPH-1:0][2*FW-1:0]     words,
  output logic [NPH-1:0][FW-1:0]       h_len,
  output logic [NPH-1:0][FW-1:0]       v_len
);

  localparam logic [FW-1:0] ONE = FW'(1);

  logic [1:0][NPH-1:0][FW-1:0] eff;
  logic [1:0][NPH-1:0][FW-1:0] shadow;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam logic [FW-1:0] LIMIT = (g == 0) ? FW'(MAX_W) : FW'(MAX_H);
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      logic [FW-1:0] raw;
      assign raw = words[p][g*FW +: FW];
      if (p == int'(PH_ACT)) begin : g_clamp
        always_comb begin
          if (raw == '0)          eff[g][p] = ONE;
          else if (raw > LIMIT)   eff[g][p] = LIMIT;
          else                    eff[g][p] = raw;
        end
      end else begin : g_floor
        assign eff[g][p] = (raw == '0) ? ONE : raw;
      end
      always_ff @(posedge clk) begin
        if (!rst_n)     shadow[g][p] <= ONE;
        else if (load)  shadow[g][p] <= eff[g][p];
      end
    end
  end

  assign h_len = shadow[0];
  assign v_len = shadow[1];

endmodule

// File: rtl/disp_sync_axis.sv
module disp_sync_axis
  import disp_sync_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic [NPH-1:0][FW-1:0] len,
  output phase_t                 phase,
  output logic [FW-1:0]          pos,
  output logic                   wrap
);

  localparam logic [FW-1:0] ONE = FW'(1);

  logic [FW-1:0] cnt;
  logic [FW-1:0] cur_len;
  logic          last;

  always_comb begin
    cur_len = ONE;
    for (int i = 0; i < NPH; i++)
      if (phase == phase_t'(i)) cur_len = len[i];
  end

  assign last = (cnt == cur_len - ONE);
  assign wrap = step && last && (phase == PH_FRONT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_REF;
      cnt   <= '0;
      pos   <= '0;
    end else if (step) begin
      if (last) begin
        phase <= next_phase(phase);
        cnt   <= '0;
        if (phase == PH_BACK) pos <= '0;
      end else begin
        cnt <= cnt + ONE;
        if (phase == PH_ACT) pos <= pos + ONE;
      end
    end
  end

endmodule

// File: rtl/disp_sync_gen.sv
module disp_sync_gen
  import disp_sync_pkg::*;
#(
  parameter int FW    = 16,
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_ce,
  input  logic [2*FW-1:0] tm_ref,
  input  logic [2*FW-1:0] tm_sync,
  input  logic [2*FW-1:0] tm_back,
  input  logic [2*FW-1:0] tm_front,
  input  logic [2*FW-1:0] tm_active,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [FW-1:0]   pos_x,
  output logic [FW-1:0]   pos_y
);

  logic [NPH-1:0][2*FW-1:0] words;
  logic [NPH-1:0][FW-1:0]   h_len;
  logic [NPH-1:0][FW-1:0]   v_len;
  logic   pending;
  logic   h_step, h_wrap, v_wrap, frame_end, cfg_load;
  phase_t h_phase, v_phase;

  always_comb begin
    words[PH_REF]   = tm_ref;
    words[PH_SYNC]  = tm_sync;
    words[PH_BACK]  = tm_back;
    words[PH_ACT]   = tm_active;
    words[PH_FRONT] = tm_front;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b1;
    else        pending <= 1'b0;
  end

  assign h_step    = pix_ce && !pending;
  assign frame_end = h_wrap && v_wrap;
  assign cfg_load  = pending || frame_end;

  disp_sync_cfg #(.FW(FW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .words (words),
    .h_len (h_len),
    .v_len (v_len)
  );

  disp_sync_axis #(.FW(FW)) u_h (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (h_step),
    .len   (h_len),
    .phase (h_phase),
    .pos   (pos_x),
    .wrap  (h_wrap)
  );

  disp_sync_axis #(.FW(FW)) u_v (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (h_wrap),
    .len   (v_len),
    .phase (v_phase),
    .pos   (pos_y),
    .wrap  (v_wrap)
  );

  assign hsync = (h_phase == PH_SYNC);
  assign vsync = (v_phase == PH_SYNC);
  assign de    = (h_phase == PH_ACT) && (v_phase == PH_ACT);

endmodule

// File: rtl/disp_sync_chk.sv
module disp_sync_chk
  import disp_sync_pkg::*;
#(
  parameter int FW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pix_ce,
  input logic                   hsync,
  input logic                   vsync,
  input logic                   de,
  input logic [FW-1:0]          pos_x,
  input logic [FW-1:0]          pos_y,
  input logic                   line_end,
  input logic                   cfg_load,
  input logic [NPH-1:0][FW-1:0] h_len
);

  p_sync_vs_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !de);

  p_vsync_at_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync != $past(vsync)) |-> $past(line_end));

  p_x_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pos_x < h_len[PH_ACT]));

  p_x_starts_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> (pos_x == '0));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_ce) |-> $stable({hsync, vsync, de, pos_x, pos_y}));

  p_cfg_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_len) |-> $past(cfg_load));

endmodule

bind disp_sync_gen disp_sync_chk #(.FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_ce   (pix_ce),
  .hsync    (hsync),
  .vsync    (vsync),
  .de       (de),
  .pos_x    (pos_x),
  .pos_y    (pos_y),
  .line_end (h_wrap),
  .cfg_load (cfg_load),
  .h_len    (h_len)
);

// File: tb/disp_sync_gen_bench.sv
module disp_sync_gen_bench;

  localparam int MAXW = 1366;
  localparam int MAXH = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b0;
  logic [31:0] tm_ref = '0, tm_sync = '0, tm_back = '0, tm_front = '0, tm_active = '0;
  logic        hsync, vsync, de;
  logic [15:0] pos_x, pos_y;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int lh[5], lv[5];
  int mh[5], mv[5];
  int moff, mline, last_x, last_y;

  always #10 clk = ~clk;

  disp_sync_gen u_disp_sync_gen (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .tm_ref(tm_ref), .tm_sync(tm_sync), .tm_back(tm_back),
    .tm_front(tm_front), .tm_active(tm_active),
    .hsync(hsync), .vsync(vsync), .de(de), .pos_x(pos_x), .pos_y(pos_y)
  );

  function automatic int eff(int v, int idx, int lim);
    if (v == 0) return 1;
    if (idx == 3 && v > lim) return lim;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (off=%0d line=%0d)", req, act, exp, moff, mline);
    end
  endtask

  task automatic set_cfg(int h0, int h1, int h2, int h3, int h4,
                         int v0, int v1, int v2, int v3, int v4);
    lh[0] = h0; lh[1] = h1; lh[2] = h2; lh[3] = h3; lh[4] = h4;
    lv[0] = v0; lv[1] = v1; lv[2] = v2; lv[3] = v3; lv[4] = v4;
    tm_ref    = {16'(v0), 16'(h0)};
    tm_sync   = {16'(v1), 16'(h1)};
    tm_back   = {16'(v2), 16'(h2)};
    tm_active = {16'(v3), 16'(h3)};
    tm_front  = {16'(v4), 16'(h4)};
  endtask

  task automatic load_model();
    for (int i = 0; i < 5; i++) begin
      mh[i] = eff(lh[i], i, MAXW);
      mv[i] = eff(lv[i], i, MAXH);
    end
  endtask

  task automatic check_outputs(string tag);
    int hs0, vs0, ex, ey;
    bit hact, vact;
    hs0 = mh[0] + mh[1] + mh[2];
    vs0 = mv[0] + mv[1] + mv[2];
    hact = (moff >= hs0) && (moff < hs0 + mh[3]);
    vact = (mline >= vs0) && (mline < vs0 + mv[3]);
    ex = hact ? moff - hs0 : last_x;
    ey = vact ? mline - vs0 : last_y;
    last_x = ex;
    last_y = ey;
    chk({tag, " R3 hsync"}, int'(hsync), int'(moff >= mh[0] && moff < mh[0] + mh[1]));
    chk({tag, " R2 vsync"}, int'(vsync), int'(mline >= mv[0] && mline < mv[0] + mv[1]));
    chk({tag, " R4 de"}, int'(de), int'(hact && vact));
    chk({tag, " R1 R5 pos_x"}, int'(pos_x), ex);
    chk({tag, " R5 pos_y"}, int'(pos_y), ey);
  endtask

  task automatic model_step();
    int ht, vt;
    ht = mh[0] + mh[1] + mh[2] + mh[3] + mh[4];
    vt = mv[0] + mv[1] + mv[2] + mv[3] + mv[4];
    moff++;
    if (moff == ht) begin
      moff = 0;
      mline++;
      if (mline == vt) begin
        mline = 0;
        load_model();
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_ce = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 hsync", int'(hsync), 0);
    chk("R10 vsync", int'(vsync), 0);
    chk("R10 de", int'(de), 0);
    chk("R10 pos_x", int'(pos_x), 0);
    chk("R10 pos_y", int'(pos_y), 0);
    rst_n = 1'b1;
    pix_ce = 1'b1;
    @(negedge clk);
    pix_ce = 1'b0;
    load_model();
    moff = 0; mline = 0; last_x = 0; last_y = 0;
    check_outputs("R9 R10 load-clock");
  endtask

  task automatic run(int n, int gap_every, string tag);
    for (int i = 0; i < n; i++) begin
      pix_ce = 1'b1;
      @(negedge clk);
      pix_ce = 1'b0;
      model_step();
      check_outputs(tag);
      if (gap_every > 0 && (i % gap_every) == 0) begin
        repeat (3) @(negedge clk);
        check_outputs({tag, " R9 idle"});
      end
    end
  endtask

  initial begin
    set_cfg(1, 2, 3, 4, 2, 1, 1, 2, 3, 1);
    do_reset();
    run(250, 0, "R1");

    do_reset();
    run(200, 7, "R9");

    set_cfg(0, 1, 0, 3, 0, 1, 0, 2, 2, 0);
    do_reset();
    run(120, 0, "R7");

    set_cfg(1, 1, 1, 2000, 1, 1, 1, 1, 1, 1);
    do_reset();
    run(8300, 0, "R6 width");

    set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 1000, 1);
    do_reset();
    run(4000, 0, "R6 height");

    set_cfg(1, 2, 3, 4, 2, 1, 1, 2, 3, 1);
    do_reset();
    run(30, 0, "R8 before");
    set_cfg(1, 1, 2, 5, 3, 1, 2, 1, 4, 2);
    run(400, 0, "R8 after");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule